// File: doc/BRIEF.md
# Page Uniformity Evaluator

This block decides whether one page of address space falls under a single protection rule, or under none. If it does, a translation cache may store the permission result for the whole page. If it does not, the cache must fall back to byte granularity and store nothing. Each query carries an address. The block clears the page-offset bits of that address to find the page, then compares the page against the decoded start and end of every protection entry.

Entries are examined in priority order, with index 0 first. An entry that is switched off is passed over. The first active entry that overlaps the page decides the result:

- If that entry spans the whole page, the page is uniform.
- If that entry begins or ends inside the page, the page is not uniform.
- If protection is not implemented, or no active entry touches the page, the page is uniform.

The result is registered and appears one cycle after the query strobe, together with a done pulse.

Top module: `page_uniform_eval`

## Requirements
- R1: The page of a query is the query address with its low PAGE_BITS bits cleared, and it ends at that value plus 2^PAGE_BITS minus 1. The low bits of the query address have no effect on the result.
- R2: When prot_impl is 0, page_uniform is 1 for every query.
- R3: When no bit of ent_active is set, page_uniform is 1.
- R4: An entry whose ent_active bit is 0 never decides the result, whatever its start and end.
- R5: When the deciding entry has start <= page start and end >= page end, page_uniform is 1.
- R6: When the deciding entry does not span the page but has its start or its end inside the page, page_uniform is 0.
- R7: When no active entry spans the page or has an end point inside it, page_uniform is 1.
- R8: The deciding entry is the lowest-index active entry that spans the page or has an end point inside it. Entries with a higher index are ignored.
- R9: done is 1 exactly in the cycle after a cycle with query_valid high, and page_uniform then shows the result for that query. Without a query, page_uniform holds its value.
- R10: After reset, done is 0 and page_uniform is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| query_valid | input | 1 | Query strobe |
| query_addr | input | ADDR_W | Query address |
| prot_impl | input | 1 | Protection is implemented |
| ent_start | input | NUM_ENTRIES*ADDR_W | Entry start addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_end | input | NUM_ENTRIES*ADDR_W | Entry end addresses (inclusive), same packing as ent_start |
| ent_active | input | NUM_ENTRIES | Bit i set when entry i is not off |
| done | output | 1 | Result valid pulse |
| page_uniform | output | 1 | 1: the whole page may be cached; 0: byte granularity only |

## Verification
The bench builds the block with three entries, an 8-bit address and 4-byte pages. At that size the address space holds only 64 pages. A sweep over every page, repeated with many pseudo-random entry sets, therefore covers every case: full cover, start inside the page, end inside the page, entries that lie fully outside, and inverted ranges. Within each set, entries are active or off in varied combinations, so priority order is exercised at all three positions. Directed cases pin down the priority between entries and the effect of inactive entries, and show that the offset bits of the query address do not change the result.

// File: rtl/pue_pkg.sv
package pue_pkg;
  typedef struct packed {
    logic covers;
    logic touches;
  } pue_class_t;
endpackage

// File: rtl/pue_entry_class.sv
module pue_entry_class
  import pue_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] page_lo,
  input  logic [ADDR_W-1:0] page_hi,
  input  logic [ADDR_W-1:0] ent_lo,
  input  logic [ADDR_W-1:0] ent_hi,
  output pue_class_t        cls
);
  logic lo_in, hi_in;

  always_comb begin
    lo_in       = (ent_lo >= page_lo) && (ent_lo <= page_hi);
    hi_in       = (ent_hi >= page_lo) && (ent_hi <= page_hi);
    cls.covers  = (ent_lo <= page_lo) && (ent_hi >= page_hi);
    cls.touches = lo_in || hi_in;
  end
endmodule

// File: rtl/pue_first_pick.sv
module pue_first_pick
  import pue_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  pue_class_t [NUM_ENTRIES-1:0] cls,
  input  logic [NUM_ENTRIES-1:0]       active,
  input  logic                         impl,
  output logic                         uniform
);
  logic taken;
  logic pick_uni;

  always_comb begin
    taken    = 1'b0;
    pick_uni = 1'b1;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!taken && active[i] && (cls[i].covers || cls[i].touches)) begin
        taken    = 1'b1;
        pick_uni = cls[i].covers;
      end
    end
    uniform = impl ? pick_uni : 1'b1;
  end
endmodule

// File: rtl/page_uniform_eval.sv
module page_uniform_eval
  import pue_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 16,
  parameter int PAGE_BITS   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          query_valid,
  input  logic [ADDR_W-1:0]             query_addr,
  input  logic                          prot_impl,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_start,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_end,
  input  logic [NUM_ENTRIES-1:0]        ent_active,
  output logic                          done,
  output logic                          page_uniform
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic [ADDR_W-1:0] page_lo, page_hi;
  pue_class_t [NUM_ENTRIES-1:0] cls;
  logic uniform_nxt;
  logic done_d, done_q;
  logic uni_d, uni_q;

  assign page_lo = query_addr & ~OFF_MASK;
  assign page_hi = page_lo | OFF_MASK;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
    pue_entry_class #(.ADDR_W(ADDR_W)) u_cls (
      .page_lo (page_lo),
      .page_hi (page_hi),
      .ent_lo  (ent_start[gi*ADDR_W +: ADDR_W]),
      .ent_hi  (ent_end[gi*ADDR_W +: ADDR_W]),
      .cls     (cls[gi])
    );
  end

  pue_first_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .cls     (cls),
    .active  (ent_active),
    .impl    (prot_impl),
    .uniform (uniform_nxt)
  );

  always_comb begin
    done_d = query_valid;
    uni_d  = query_valid ? uniform_nxt : uni_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      uni_q  <= 1'b1;
    end else begin
      done_q <= done_d;
      uni_q  <= uni_d;
    end
  end

  assign done         = done_q;
  assign page_uniform = uni_q;
endmodule

// File: rtl/pue_checker.sv
module pue_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 16,
  parameter int PAGE_BITS   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   query_valid,
  input logic [ADDR_W-1:0]      query_addr,
  input logic                   prot_impl,
  input logic [ADDR_W-1:0]      e0_start,
  input logic [ADDR_W-1:0]      e0_end,
  input logic [NUM_ENTRIES-1:0] ent_active,
  input logic                   done,
  input logic                   page_uniform
);
  localparam logic [ADDR_W-1:0] LOWM = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic [ADDR_W-1:0] pg_s, pg_e;
  logic e0_span, e0_edge;

  always_comb begin
    pg_s    = query_addr & ~LOWM;
    pg_e    = pg_s + LOWM;
    e0_span = (e0_start <= pg_s) && (e0_end >= pg_e);
    e0_edge = ((e0_start >= pg_s) && (e0_start <= pg_e)) ||
              ((e0_end >= pg_s) && (e0_end <= pg_e));
  end

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    query_valid |=> done);
  assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !query_valid |=> !done);
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !query_valid |=> $stable(page_uniform));
  assert_no_prot_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid && !prot_impl) |=> page_uniform);
  assert_no_active_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid && ent_active == '0) |=> page_uniform);
  assert_first_covers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid && prot_impl && ent_active[0] && e0_span) |=> page_uniform);
  assert_first_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid && prot_impl && ent_active[0] && e0_edge && !e0_span) |=> !page_uniform);
endmodule

bind page_uniform_eval pue_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ADDR_W      (ADDR_W),
  .PAGE_BITS   (PAGE_BITS)
) u_pue_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .query_valid  (query_valid),
  .query_addr   (query_addr),
  .prot_impl    (prot_impl),
  .e0_start     (ent_start[ADDR_W-1:0]),
  .e0_end       (ent_end[ADDR_W-1:0]),
  .ent_active   (ent_active),
  .done         (done),
  .page_uniform (page_uniform)
);

// File: tb/page_uniform_eval_bench.sv
`timescale 1ns/1ps
module page_uniform_eval_bench;
  localparam int NE = 3;
  localparam int AW = 8;
  localparam int PB = 2;
  localparam int MASK = (1 << PB) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic qv;
  logic [AW-1:0] qa;
  logic impl;
  logic [NE*AW-1:0] es, ee;
  logic [NE-1:0] ea;
  logic done, uni;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  page_uniform_eval #(.NUM_ENTRIES(NE), .ADDR_W(AW), .PAGE_BITS(PB)) u_page_uniform_eval (
    .clk(clk), .rst_n(rst_n), .query_valid(qv), .query_addr(qa), .prot_impl(impl),
    .ent_start(es), .ent_end(ee), .ent_active(ea), .done(done), .page_uniform(uni)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (addr %0h act %b)", req, act, exp, qa, ea);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  function automatic void ref_eval(input int a, output logic u, output string tag);
    int ps, pe, s, e;
    ps = a & ~MASK;
    pe = ps + MASK;
    u = 1'b1;
    tag = "R7";
    if (!impl) begin u = 1'b1; tag = "R2"; return; end
    if (ea == '0) begin u = 1'b1; tag = "R3"; return; end
    for (int i = 0; i < NE; i++) begin
      s = int'(es[i*AW +: AW]);
      e = int'(ee[i*AW +: AW]);
      if (ea[i]) begin
        if (s <= ps && e >= pe) begin u = 1'b1; tag = (i > 0) ? "R8/R5" : "R5"; return; end
        if ((s >= ps && s <= pe) || (e >= ps && e <= pe)) begin
          u = 1'b0; tag = (i > 0) ? "R8/R6" : "R6"; return;
        end
      end
    end
  endfunction

  task automatic query(input int a);
    logic expu;
    string tag;
    @(negedge clk);
    qa = AW'(a);
    qv = 1'b1;
    ref_eval(a, expu, tag);
    @(negedge clk);
    qv = 1'b0;
    check("R9 done", done, 1'b1);
    check(tag, uni, expu);
  endtask

  task automatic set_ent(input int i, input int s, input int e);
    es[i*AW +: AW] = AW'(s);
    ee[i*AW +: AW] = AW'(e);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic held;
    rst_n = 1'b0; qv = 1'b0; qa = '0; impl = 1'b1; es = '0; ee = '0; ea = '0;
    #12;
    check("R10 done", done, 1'b0);
    check("R10 uniform", uni, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle done", done, 1'b0);

    // R2: no protection, partial entry present
    set_ent(0, 8'h11, 8'h12); ea = 3'b001; impl = 1'b0;
    query(8'h10);
    check("R2", uni, 1'b1);
    impl = 1'b1;
    query(8'h10);
    check("R6 directed", uni, 1'b0);
    // R9 hold: no query, change inputs, result must stay
    held = uni;
    @(negedge clk);
    set_ent(0, 8'h00, 8'hff);
    @(negedge clk);
    check("R9 hold", uni, held);
    check("R9 no done", done, 1'b0);
    // R3
    ea = 3'b000; set_ent(0, 8'h11, 8'h12);
    query(8'h10);
    check("R3", uni, 1'b1);
    // R4: inactive partial entry 0, entry 1 covers
    set_ent(1, 8'h00, 8'h7f); ea = 3'b010;
    query(8'h10);
    check("R4", uni, 1'b1);
    // R8: entry 0 covers, entry 1 partial
    set_ent(0, 8'h00, 8'hff); set_ent(1, 8'h13, 8'h20); ea = 3'b011;
    query(8'h10);
    check("R8 first covers", uni, 1'b1);
    // R8: entry 0 partial, entry 1 covers
    set_ent(0, 8'h0c, 8'h10); set_ent(1, 8'h00, 8'hff); ea = 3'b011;
    query(8'h10);
    check("R8 first partial", uni, 1'b0);
    // R7: entry outside, later entry far away too
    set_ent(0, 8'h20, 8'h2f); set_ent(1, 8'h40, 8'h4f); ea = 3'b011;
    query(8'h10);
    check("R7", uni, 1'b1);
    // R1: offset bits do not matter; end at page end exactly inside
    set_ent(0, 8'h00, 8'h13); ea = 3'b001;
    for (int lo = 0; lo <= MASK; lo++) begin
      query(8'h10 | lo);
      check("R1 offset", uni, 1'b1);
    end
    set_ent(0, 8'h00, 8'h12);
    for (int lo = 0; lo <= MASK; lo++) begin
      query(8'h10 | lo);
      check("R1 end inside", uni, 1'b0);
    end

    // Sweep: pseudo-random entry sets, every page, random offset
    for (int c = 0; c < 150; c++) begin
      for (int i = 0; i < NE; i++) begin
        seed = nxt(seed); es[i*AW +: AW] = seed[23:16];
        seed = nxt(seed);
        ee[i*AW +: AW] = (seed[31]) ? seed[23:16] : es[i*AW +: AW] + {3'b0, seed[20:16]};
      end
      seed = nxt(seed);
      ea = seed[18:16];
      impl = (seed[27:24] != 4'h0);
      for (int p = 0; p < (1 << (AW - PB)); p++) begin
        seed = nxt(seed);
        query((p << PB) | int'(seed[17:16]));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule